// File: doc/BRIEF.md
# Mode-Banked Integer Register File

This block is the integer register file of a load/store RISC core. Sixteen architectural register names, each given by a 4-bit specifier, are mapped onto a 31-entry array of 32-bit words. The current processor mode selects the mapping. Privileged modes therefore see private copies of some registers, which lets an exception handler run without first saving those registers.

Three combinational read ports feed the ALU operands and the address or store-data operand. Two write ports let an ALU result (port 0) and a load result (port 1) be written back in the same cycle. Specifier 15 names the program counter. A read of it returns the supplied PC value plus 8, and a write to it is not stored: it is passed out as a registered strobe with the data. A read of an entry that is written in the same cycle returns the new data.

Top module: `rfb_regfile`

## Requirements
- R1: After reset every stored entry reads as zero and `pc_wr_stb` is low. Reset is asynchronous and active low, and its release is synchronised with two flops, so writes are accepted from the third rising edge after `rst_n` rises.
- R2: A read of specifier 15 on any port, in any mode, returns `pc_in + 8`.
- R3: A write to specifiers 0 to 14 is stored at the rising edge. From then on it is returned on every read port for the same specifier in any mode that maps it to the same entry.
- R4: A read of an entry that a write port targets in the same cycle returns that write's data combinationally.
- R5: When both write ports target the same entry in one cycle, port 1 wins. This holds for both the stored value and the same-cycle read.
- R6: A write to specifier 15 changes no entry. On the next cycle `pc_wr_stb` is high and `pc_wr_data` holds the written data, taken from port 1 when both ports write 15. Otherwise `pc_wr_stb` is low.
- R7: Mode encodings are 0 user, 1 fast-interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined-instruction and 6 system. Specifiers 0 to 7 map to one shared set of entries in every mode. Specifiers 8 to 12 are shared by every mode except fast-interrupt.
- R8: Fast-interrupt mode has its own private entries for specifiers 8 to 14.
- R9: Modes 2 to 5 each have their own private entries for specifiers 13 and 14. User mode and system mode share the base entries.
- R10: The undefined mode encoding 7 maps exactly like user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Current processor mode |
| pc_in | input | 32 | Address of the current instruction |
| rd_addr0 | input | 4 | Read port 0 specifier |
| rd_addr1 | input | 4 | Read port 1 specifier |
| rd_addr2 | input | 4 | Read port 2 specifier |
| rd_data0 | output | 32 | Read port 0 data |
| rd_data1 | output | 32 | Read port 1 data |
| rd_data2 | output | 32 | Read port 2 data |
| wr_en0 | input | 1 | Write port 0 (ALU result) enable |
| wr_addr0 | input | 4 | Write port 0 specifier |
| wr_data0 | input | 32 | Write port 0 data |
| wr_en1 | input | 1 | Write port 1 (load result) enable |
| wr_addr1 | input | 4 | Write port 1 specifier |
| wr_data1 | input | 32 | Write port 1 data |
| pc_wr_stb | output | 1 | A PC write occurred on the previous cycle |
| pc_wr_data | output | 32 | Data of that PC write |

## Verification
Directed sequences write a specifier in one mode and read it back in other modes. This tells a shared entry apart from a private one for the fast-interrupt range, for the banked pair 13 and 14, and for the system and undefined encodings. Same-cycle collisions of the two write ports, and of a write with a read, separate the priority rule from the bypass rule, and PC-specifier writes show that no entry is changed. Long random runs over all eight mode codes and all specifiers are compared against a bench model of the 31 entries, which catches mapping slips that the directed cases miss.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  localparam int SPEC_W       = 4;
  localparam int MODE_W       = 3;
  localparam int PHYS_N       = 31;
  localparam int PHYS_W       = $clog2(PHYS_N);
  localparam int PC_SPEC      = 15;
  localparam int FIQ_LO_SPEC  = 8;
  localparam int PAIR_LO_SPEC = 13;
  localparam int FIQ_BASE     = 16;
  localparam int PAIR_BASE    = FIQ_BASE + (PC_SPEC - FIQ_LO_SPEC);
  localparam int PAIR_SIZE    = PC_SPEC - PAIR_LO_SPEC;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 3'd0,
    MODE_FIQ = 3'd1,
    MODE_IRQ = 3'd2,
    MODE_SVC = 3'd3,
    MODE_ABT = 3'd4,
    MODE_UND = 3'd5,
    MODE_SYS = 3'd6
  } cpu_mode_e;

  // Specifier plus mode to physical entry index.
  function automatic logic [PHYS_W-1:0] map_phys(input logic [MODE_W-1:0] mode,
                                                 input logic [SPEC_W-1:0] spec);
    int s;
    int idx;
    s   = int'(spec);
    idx = s;
    if (mode == MODE_FIQ && s >= FIQ_LO_SPEC && s < PC_SPEC) begin
      idx = FIQ_BASE + s - FIQ_LO_SPEC;
    end else if (s >= PAIR_LO_SPEC && s < PC_SPEC &&
                 mode >= MODE_IRQ && mode <= MODE_UND) begin
      idx = PAIR_BASE + PAIR_SIZE * (int'(mode) - int'(MODE_IRQ)) + s - PAIR_LO_SPEC;
    end
    return PHYS_W'(idx);
  endfunction
endpackage

// File: rtl/rfb_spec_decode.sv
module rfb_spec_decode
  import rfb_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [SPEC_W-1:0] spec,
  output logic [PHYS_W-1:0] phys,
  output logic              is_pc
);
  always_comb begin
    is_pc = (spec == SPEC_W'(PC_SPEC));
    phys  = map_phys(mode, spec);
  end
endmodule

// File: rtl/rfb_write_arb.sv
module rfb_write_arb
  import rfb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                           we0,
  input  logic [PHYS_W-1:0]              phys0,
  input  logic                           pc0,
  input  logic [DATA_W-1:0]              wd0,
  input  logic                           we1,
  input  logic [PHYS_W-1:0]              phys1,
  input  logic                           pc1,
  input  logic [DATA_W-1:0]              wd1,
  output logic [PHYS_N-1:0]              ent_we,
  output logic [PHYS_N-1:0][DATA_W-1:0]  ent_wd,
  output logic                           pc_hit,
  output logic [DATA_W-1:0]              pc_data
);
  logic act0;
  logic act1;

  assign act0 = we0 && !pc0;
  assign act1 = we1 && !pc1;

  // Per-entry select; port 1 (load writeback) takes priority.
  for (genvar i = 0; i < PHYS_N; i++) begin : g_ent
    logic hit0;
    logic hit1;
    assign hit0      = act0 && (phys0 == PHYS_W'(i));
    assign hit1      = act1 && (phys1 == PHYS_W'(i));
    assign ent_we[i] = hit0 || hit1;
    assign ent_wd[i] = hit1 ? wd1 : wd0;
  end

  always_comb begin
    pc_hit  = (we0 && pc0) || (we1 && pc1);
    pc_data = (we1 && pc1) ? wd1 : wd0;
  end
endmodule

// File: rtl/rfb_read_port.sv
module rfb_read_port
  import rfb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PC_AHEAD  = 8
) (
  input  logic [PHYS_N-1:0][DATA_W-1:0] regs,
  input  logic [PHYS_N-1:0]             ent_we,
  input  logic [PHYS_N-1:0][DATA_W-1:0] ent_wd,
  input  logic [PHYS_W-1:0]             phys,
  input  logic                          is_pc,
  input  logic [DATA_W-1:0]             pc_in,
  output logic [DATA_W-1:0]             data
);
  always_comb begin
    if (is_pc) begin
      data = pc_in + DATA_W'(PC_AHEAD);
    end else if (ent_we[phys]) begin
      data = ent_wd[phys];
    end else begin
      data = regs[phys];
    end
  end
endmodule

// File: rtl/rfb_regfile.sv
module rfb_regfile
  import rfb_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PC_AHEAD = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [3:0]        rd_addr0,
  input  logic [3:0]        rd_addr1,
  input  logic [3:0]        rd_addr2,
  output logic [DATA_W-1:0] rd_data0,
  output logic [DATA_W-1:0] rd_data1,
  output logic [DATA_W-1:0] rd_data2,
  input  logic              wr_en0,
  input  logic [3:0]        wr_addr0,
  input  logic [DATA_W-1:0] wr_data0,
  input  logic              wr_en1,
  input  logic [3:0]        wr_addr1,
  input  logic [DATA_W-1:0] wr_data1,
  output logic              pc_wr_stb,
  output logic [DATA_W-1:0] pc_wr_data
);
  localparam int N_RD  = 3;
  localparam int N_WR  = 2;
  localparam int N_DEC = N_RD + N_WR;

  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // Specifier decode for every port: 0..2 read, 3..4 write.
  logic [N_DEC-1:0][SPEC_W-1:0] dec_spec;
  logic [N_DEC-1:0][PHYS_W-1:0] dec_phys;
  logic [N_DEC-1:0]             dec_pc;

  assign dec_spec = {wr_addr1, wr_addr0, rd_addr2, rd_addr1, rd_addr0};

  for (genvar p = 0; p < N_DEC; p++) begin : g_dec
    rfb_spec_decode u_dec (
      .mode  (mode),
      .spec  (dec_spec[p]),
      .phys  (dec_phys[p]),
      .is_pc (dec_pc[p])
    );
  end

  // Write arbitration.
  logic [PHYS_N-1:0]             ent_we;
  logic [PHYS_N-1:0][DATA_W-1:0] ent_wd;
  logic                          pc_hit;
  logic [DATA_W-1:0]             pc_data;

  rfb_write_arb #(.DATA_W(DATA_W)) u_arb (
    .we0     (wr_en0),
    .phys0   (dec_phys[N_RD]),
    .pc0     (dec_pc[N_RD]),
    .wd0     (wr_data0),
    .we1     (wr_en1),
    .phys1   (dec_phys[N_RD+1]),
    .pc1     (dec_pc[N_RD+1]),
    .wd1     (wr_data1),
    .ent_we  (ent_we),
    .ent_wd  (ent_wd),
    .pc_hit  (pc_hit),
    .pc_data (pc_data)
  );

  // Storage: per-entry clock enable, asynchronous clear.
  logic [PHYS_N-1:0][DATA_W-1:0] regs_q;
  logic                          gate_we;

  assign gate_we = rst_sync_n;

  for (genvar i = 0; i < PHYS_N; i++) begin : g_store
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        regs_q[i] <= '0;
      end else if (gate_we && ent_we[i]) begin
        regs_q[i] <= ent_wd[i];
      end
    end
  end

  // PC write strobe: next-state and register.
  logic              pc_stb_d;
  logic [DATA_W-1:0] pc_dat_d;

  always_comb begin
    pc_stb_d = pc_hit;
    pc_dat_d = pc_hit ? pc_data : pc_wr_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_wr_stb  <= 1'b0;
      pc_wr_data <= '0;
    end else begin
      pc_wr_stb  <= pc_stb_d;
      pc_wr_data <= pc_dat_d;
    end
  end

  // Read ports.
  logic [N_RD-1:0][DATA_W-1:0] rd_all;

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    rfb_read_port #(.DATA_W(DATA_W), .PC_AHEAD(PC_AHEAD)) u_rd (
      .regs   (regs_q),
      .ent_we (ent_we),
      .ent_wd (ent_wd),
      .phys   (dec_phys[r]),
      .is_pc  (dec_pc[r]),
      .pc_in  (pc_in),
      .data   (rd_all[r])
    );
  end

  assign rd_data0 = rd_all[0];
  assign rd_data1 = rd_all[1];
  assign rd_data2 = rd_all[2];
endmodule

// File: rtl/rfb_checker.sv
module rfb_checker
  import rfb_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  mode,
  input logic [31:0] pc_in,
  input logic [3:0]  rd_addr0,
  input logic [31:0] rd_data0,
  input logic        wr_en0,
  input logic [3:0]  wr_addr0,
  input logic [31:0] wr_data0,
  input logic        wr_en1,
  input logic [3:0]  wr_addr1,
  input logic [31:0] wr_data1,
  input logic        pc_wr_stb,
  input logic [31:0] pc_wr_data
);
  logic              armed;
  logic [PHYS_W-1:0] pr;
  logic [PHYS_W-1:0] pw0;
  logic [PHYS_W-1:0] pw1;
  logic              st0;
  logic              st1;
  logic              pcw0;
  logic              pcw1;
  logic              cur_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_comb begin
    pr      = map_phys(mode, rd_addr0);
    pw0     = map_phys(mode, wr_addr0);
    pw1     = map_phys(mode, wr_addr1);
    pcw0    = wr_en0 && (wr_addr0 == 4'd15);
    pcw1    = wr_en1 && (wr_addr1 == 4'd15);
    st0     = wr_en0 && (wr_addr0 != 4'd15);
    st1     = wr_en1 && (wr_addr1 != 4'd15);
    cur_hit = (st0 && pw0 == pr) || (st1 && pw1 == pr);
  end

  AST_PC_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr0 == 4'd15) |-> (rd_data0 == pc_in + 32'd8)); // R2

  AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(st0) && !($past(st1) && $past(pw1) == $past(pw0)) &&
     rd_addr0 != 4'd15 && pr == $past(pw0) && !cur_hit)
    |-> (rd_data0 == $past(wr_data0))); // R3

  AST_PORT1_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(st0) && $past(st1) && $past(pw1) == $past(pw0) &&
     rd_addr0 != 4'd15 && pr == $past(pw1) && !cur_hit)
    |-> (rd_data0 == $past(wr_data1))); // R5

  AST_PC_STROBE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (pcw0 || pcw1) |=> (pc_wr_stb && pc_wr_data == $past(pcw1 ? wr_data1 : wr_data0))); // R6

  AST_PC_STROBE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !(pcw0 || pcw1) |=> !pc_wr_stb); // R6
endmodule

bind rfb_regfile rfb_checker u_rfb_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .mode       (mode),
  .pc_in      (pc_in),
  .rd_addr0   (rd_addr0),
  .rd_data0   (rd_data0),
  .wr_en0     (wr_en0),
  .wr_addr0   (wr_addr0),
  .wr_data0   (wr_data0),
  .wr_en1     (wr_en1),
  .wr_addr1   (wr_addr1),
  .wr_data1   (wr_data1),
  .pc_wr_stb  (pc_wr_stb),
  .pc_wr_data (pc_wr_data)
);

// File: tb/rfb_regfile_bench.sv
module rfb_regfile_bench;
  logic        clk;
  logic        rst_n;
  logic [2:0]  mode;
  logic [31:0] pc_in;
  logic [3:0]  rd_addr0, rd_addr1, rd_addr2;
  logic [31:0] rd_data0, rd_data1, rd_data2;
  logic        wr_en0, wr_en1;
  logic [3:0]  wr_addr0, wr_addr1;
  logic [31:0] wr_data0, wr_data1;
  logic        pc_wr_stb;
  logic [31:0] pc_wr_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string force_tag = "";

  logic [31:0] model [31];
  bit          exp_stb;
  logic [31:0] exp_pcd;

  rfb_regfile u_rfb_regfile (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pc_in(pc_in),
    .rd_addr0(rd_addr0), .rd_addr1(rd_addr1), .rd_addr2(rd_addr2),
    .rd_data0(rd_data0), .rd_data1(rd_data1), .rd_data2(rd_data2),
    .wr_en0(wr_en0), .wr_addr0(wr_addr0), .wr_data0(wr_data0),
    .wr_en1(wr_en1), .wr_addr1(wr_addr1), .wr_data1(wr_data1),
    .pc_wr_stb(pc_wr_stb), .pc_wr_data(pc_wr_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Bench view of the bank map, written from the requirements.
  function automatic int bmap(input int m, input int s);
    if (m == 7 || m == 6) m = 0;
    if (m == 1 && s >= 8) return 16 + (s - 8);
    if (s >= 13 && m >= 2 && m <= 5) return 23 + 2 * (m - 2) + (s - 13);
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string rd_tag(input int s);
    int  p;
    bit  h0, h1;
    if (force_tag != "") return force_tag;
    if (s == 15) return "R2";
    p  = bmap(int'(mode), s);
    h0 = wr_en0 && wr_addr0 != 4'd15 && bmap(int'(mode), int'(wr_addr0)) == p;
    h1 = wr_en1 && wr_addr1 != 4'd15 && bmap(int'(mode), int'(wr_addr1)) == p;
    if (h0 && h1) return "R5";
    if (h0 || h1) return "R4";
    if (mode == 3'd7) return "R10";
    if (mode == 3'd1 && s >= 8) return "R8";
    if (s >= 13 && mode >= 3'd2 && mode <= 3'd5) return "R9";
    if (mode == 3'd0) return "R3";
    return "R7";
  endfunction

  function automatic logic [31:0] rd_exp(input int s);
    int p;
    if (s == 15) return pc_in + 32'd8;
    p = bmap(int'(mode), s);
    if (wr_en1 && wr_addr1 != 4'd15 && bmap(int'(mode), int'(wr_addr1)) == p) return wr_data1;
    if (wr_en0 && wr_addr0 != 4'd15 && bmap(int'(mode), int'(wr_addr0)) == p) return wr_data0;
    return model[p];
  endfunction

  task automatic step(input logic [2:0] m, input logic [3:0] a0, input logic [3:0] a1,
                      input logic [3:0] a2, input logic w0, input logic [3:0] x0,
                      input logic [31:0] d0, input logic w1, input logic [3:0] x1,
                      input logic [31:0] d1);
    @(negedge clk);
    chk("R6 strobe", {31'd0, pc_wr_stb}, {31'd0, exp_stb});
    if (exp_stb) chk("R6 data", pc_wr_data, exp_pcd);
    mode = m; pc_in = $urandom & 32'hFFFF_FFFC;
    rd_addr0 = a0; rd_addr1 = a1; rd_addr2 = a2;
    wr_en0 = w0; wr_addr0 = x0; wr_data0 = d0;
    wr_en1 = w1; wr_addr1 = x1; wr_data1 = d1;
    #1;
    chk(rd_tag(int'(a0)), rd_data0, rd_exp(int'(a0)));
    chk(rd_tag(int'(a1)), rd_data1, rd_exp(int'(a1)));
    chk(rd_tag(int'(a2)), rd_data2, rd_exp(int'(a2)));
    @(posedge clk);
    if (w0 && x0 != 4'd15) model[bmap(int'(m), int'(x0))] = d0;
    if (w1 && x1 != 4'd15) model[bmap(int'(m), int'(x1))] = d1;
    exp_stb = (w0 && x0 == 4'd15) || (w1 && x1 == 4'd15);
    if (w1 && x1 == 4'd15) exp_pcd = d1;
    else if (w0 && x0 == 4'd15) exp_pcd = d0;
  endtask

  task automatic rd3(input logic [2:0] m, input logic [3:0] a);
    step(m, a, a, a, 1'b0, 4'd0, 32'd0, 1'b0, 4'd0, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 31; i++) model[i] = 32'd0;
    exp_stb = 1'b0; exp_pcd = 32'd0;
    mode = 3'd0; pc_in = 32'd0;
    rd_addr0 = 4'd0; rd_addr1 = 4'd0; rd_addr2 = 4'd0;
    wr_en0 = 1'b0; wr_addr0 = 4'd0; wr_data0 = 32'd0;
    wr_en1 = 1'b0; wr_addr1 = 4'd0; wr_data1 = 32'd0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: every entry in every bank reads zero after reset.
    force_tag = "R1";
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 15; s++) rd3(3'(m), 4'(s));
    force_tag = "";

    // R9 / R10: user R13 written, banked in supervisor, shared by system and code 7.
    step(3'd0, 4'd0, 4'd0, 4'd0, 1'b1, 4'd13, 32'hA5A5_0013, 1'b0, 4'd0, 32'd0);
    rd3(3'd3, 4'd13);
    rd3(3'd6, 4'd13);
    rd3(3'd7, 4'd13);
    step(3'd4, 4'd14, 4'd14, 4'd14, 1'b1, 4'd14, 32'hAB0A_0014, 1'b0, 4'd0, 32'd0);
    rd3(3'd5, 4'd14);
    rd3(3'd4, 4'd14);

    // R8 / R7: fast-interrupt private R8, shared R5 and R10 elsewhere.
    step(3'd1, 4'd0, 4'd0, 4'd0, 1'b1, 4'd8, 32'hF1F1_0008, 1'b0, 4'd0, 32'd0);
    rd3(3'd0, 4'd8);
    rd3(3'd1, 4'd8);
    step(3'd0, 4'd0, 4'd0, 4'd0, 1'b1, 4'd5, 32'h0000_C005, 1'b1, 4'd10, 32'h0000_C010);
    rd3(3'd1, 4'd5);
    rd3(3'd2, 4'd10);
    rd3(3'd1, 4'd10);

    // R5: both ports to one entry, same-cycle read and later read.
    step(3'd0, 4'd4, 4'd4, 4'd4, 1'b1, 4'd4, 32'h1111_0004, 1'b1, 4'd4, 32'h2222_0004);
    rd3(3'd0, 4'd4);
    // R4: bypass on port 0 only.
    step(3'd2, 4'd7, 4'd7, 4'd3, 1'b1, 4'd7, 32'h0BAD_0007, 1'b0, 4'd0, 32'd0);

    // R6 / R2: PC writes, single and colliding.
    step(3'd0, 4'd15, 4'd15, 4'd15, 1'b1, 4'd15, 32'hE000_0100, 1'b0, 4'd0, 32'd0);
    step(3'd3, 4'd15, 4'd0, 4'd14, 1'b1, 4'd15, 32'hF000_0200, 1'b1, 4'd15, 32'h6000_0300);
    rd3(3'd0, 4'd0);

    // Random phase.
    for (int n = 0; n < 4000; n++) begin
      step(3'($urandom_range(0, 7)), 4'($urandom), 4'($urandom), 4'($urandom),
           1'($urandom), 4'($urandom), $urandom, 1'($urandom), 4'($urandom), $urandom);
    end
    rd3(3'd0, 4'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule